// File: doc/BRIEF.md
# Nested Affine Stream Address Generator

This block produces a stream of byte addresses for a data mover outside the processor core. The processor can then run a loop body of one instruction, and each pass of that loop receives a fresh operand. The walk covers up to four nested loop levels. Each level has its own iteration bound and its own signed byte stride, and the walk starts from a programmable base address. Every address equals the base plus the sum over the active levels of index times stride. The innermost level advances first. When a level reaches its bound it clears to zero and carries into the next outer level.

Each next address is formed from the previous one with no multiplier. The stride of the level that steps is added, and the accumulated span of each level that wraps is subtracted. This allows one address per clock while the consumer keeps ready high. Software loads the base, the bounds, the strides and the active level count through a small write port while the block is idle, then pulses start. A one-cycle done pulse marks the end of the walk.

The controller has three states: `S_IDLE`, `S_RUN` and `S_DONE`. The transitions are:
- IDLE→RUN: start while every active bound is nonzero.
- IDLE→DONE: start with a zero bound on an active level.
- RUN→DONE: a handshake on the final address.
- DONE→IDLE: unconditional, after one cycle.

Top module: `affine_stream_agu`

## Requirements
- R1: After reset, `addr_valid` and `done` are low and the block is idle.
- R2: Address number k (from 0) equals base + Σ idx_d·stride_d modulo 2^ADDR_W. The indices idx_d are the mixed-radix digits of k, with level 0 as the least significant digit and bound_d as each radix.
- R3: While ready stays high, one address is accepted in every cycle from the cycle after start until the walk ends, with no gaps.
- R4: While `addr_valid` is high and `addr_ready` is low, `addr` stays unchanged into the next cycle.
- R5: While `stream_en` is low, `addr_valid` is low. When it rises again, the stream resumes at the address that had not yet been accepted.
- R6: `done` is high for exactly one cycle, in the cycle after the handshake of the last address. The number of addresses accepted equals the product of the active bounds.
- R7: Configuration writes made while the block is not idle have no effect.
- R8: If any active level has a bound of zero, start produces no address, and `done` is high in the cycle after start.
- R9: Only levels 0 through count-1 take part in the walk. Bounds and strides of the higher levels are ignored.
- R10: Configuration write encoding, selected by `cfg_kind`:
  - 0: base (full word).
  - 1: bound of level `cfg_lvl` (low CNT_W bits).
  - 2: stride of level `cfg_lvl` (full word, two's complement).
  - 3: active level count minus one (`cfg_wdata[1:0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind selected for the write (R10) |
| cfg_lvl | input | 2 | Loop level selected for bound and stride writes |
| cfg_wdata | input | ADDR_W | Write data |
| start | input | 1 | Starts a walk when pulsed while idle |
| stream_en | input | 1 | Allows addresses to be issued |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | The consumer accepts the offered address |
| addr | output | ADDR_W | Current stream address |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
A wrong index or span register shows up as a wrong address at the very next handshake after the faulty carry, so each address is compared with its closed-form value. A mistake in the end condition shows up in the cycle after the last handshake: either `done` stays low, or an extra address is offered. Held addresses during stalls are compared against their previous value every cycle. A configuration change that slips through while the block is busy is caught at the first address of the following walk.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } agu_state_t;

    localparam logic [1:0] KIND_BASE   = 2'd0;
    localparam logic [1:0] KIND_BOUND  = 2'd1;
    localparam logic [1:0] KIND_STRIDE = 2'd2;
    localparam logic [1:0] KIND_DIMS   = 2'd3;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_LVL = 4,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              we,
    input  logic [1:0]        kind,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  bound_q  [NUM_LVL],
    output logic [ADDR_W-1:0] stride_q [NUM_LVL],
    output logic [LVL_W-1:0]  dims_m1_q
);
    logic wr_ok;
    assign wr_ok = we && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            dims_m1_q <= '0;
        end else if (wr_ok) begin
            if (kind == KIND_BASE) base_q    <= wdata;
            if (kind == KIND_DIMS) dims_m1_q <= wdata[LVL_W-1:0];
        end
    end

    for (genvar d = 0; d < NUM_LVL; d++) begin : g_lvl_regs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bound_q[d]  <= '0;
                stride_q[d] <= '0;
            end else if (wr_ok && lvl == LVL_W'(d)) begin
                if (kind == KIND_BOUND)  bound_q[d]  <= wdata[CNT_W-1:0];
                if (kind == KIND_STRIDE) stride_q[d] <= wdata;
            end
        end
    end

    // R7: while the walk is in progress, the configuration must not move
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(dims_m1_q)));
endmodule

// File: rtl/agu_level.sv
module agu_level #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  bound,
    output logic              last,
    output logic [CNT_W-1:0]  idx,
    output logic [ADDR_W-1:0] span
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= '0;
            span <= '0;
        end else if (clr || wrap) begin
            idx  <= '0;
            span <= '0;
        end else if (step) begin
            idx  <= idx + 1'b1;
            span <= span + stride;
        end
    end

    assign last = (idx == bound - 1'b1);
endmodule

// File: rtl/affine_stream_agu.sv
module affine_stream_agu
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_LVL = 4,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [LVL_W-1:0]  cfg_lvl,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              start,
    input  logic              stream_en,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    agu_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  bound_q  [NUM_LVL];
    logic [ADDR_W-1:0] stride_q [NUM_LVL];
    logic [LVL_W-1:0]  dims_m1_q;

    logic [NUM_LVL-1:0] lvl_last, lvl_step, lvl_wrap, lvl_act, lvl_zero;
    logic [CNT_W-1:0]   lvl_idx  [NUM_LVL];
    logic [ADDR_W-1:0]  lvl_span [NUM_LVL];

    logic              fire, launch, finish, any_zero;
    logic [ADDR_W-1:0] addr_q, addr_next;

    agu_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LVL(NUM_LVL)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (state_q != S_IDLE),
        .we        (cfg_we),
        .kind      (cfg_kind),
        .lvl       (cfg_lvl),
        .wdata     (cfg_wdata),
        .base_q    (base_q),
        .bound_q   (bound_q),
        .stride_q  (stride_q),
        .dims_m1_q (dims_m1_q)
    );

    for (genvar d = 0; d < NUM_LVL; d++) begin : g_level
        assign lvl_act[d]  = (LVL_W'(d) <= dims_m1_q);
        assign lvl_zero[d] = (bound_q[d] == '0);

        agu_level #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_lvl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (launch),
            .step   (lvl_step[d]),
            .wrap   (lvl_wrap[d]),
            .stride (stride_q[d]),
            .bound  (bound_q[d]),
            .last   (lvl_last[d]),
            .idx    (lvl_idx[d]),
            .span   (lvl_span[d])
        );

        // R2: an active index never reaches its bound while walking
        assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == S_RUN && lvl_act[d]) |-> (lvl_idx[d] < bound_q[d]));
    end

    assign any_zero = |(lvl_act & lvl_zero);
    assign launch   = (state_q == S_IDLE) && start;
    assign fire     = addr_valid && addr_ready;

    // Carry chain: innermost level first; a wrap carries outward.
    always_comb begin
        logic carry;
        carry = fire;
        for (int d = 0; d < NUM_LVL; d++) begin
            lvl_step[d] = carry && lvl_act[d] && !lvl_last[d];
            lvl_wrap[d] = carry && lvl_act[d] &&  lvl_last[d];
            carry       = lvl_wrap[d];
        end
        finish = lvl_wrap[dims_m1_q];
    end

    always_comb begin
        addr_next = addr_q;
        for (int d = 0; d < NUM_LVL; d++) begin
            if (lvl_step[d]) addr_next = addr_next + stride_q[d];
            if (lvl_wrap[d]) addr_next = addr_next - lvl_span[d];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr_q <= '0;
        else if (launch) addr_q <= base_q;
        else if (fire)   addr_q <= addr_next;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = any_zero ? S_DONE : S_RUN;
            S_RUN:   if (fire && finish) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        addr_valid = (state_q == S_RUN) && stream_en;
        done       = (state_q == S_DONE);
        addr       = addr_q;
    end

    // R4: an offered but unaccepted address holds
    assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> $stable(addr));
    // R5: nothing is issued while streaming is disabled
    assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_en |-> !addr_valid);
    // R6: done lasts exactly one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: no address offered together with done
    assert_done_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid);
endmodule

// File: tb/sim_affine_stream_agu.sv
module sim_affine_stream_agu;
    localparam int NV = 4;

    // Vector table: base, level count minus one, bounds, strides
    localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_8000, 32'h0000_0100};
    localparam logic [1:0]  V_DIMS [NV] = '{2'd3, 2'd1, 2'd0, 2'd2};
    localparam logic [15:0] V_BND  [NV][4] = '{
        '{16'd2, 16'd3, 16'd2, 16'd2},
        '{16'd4, 16'd3, 16'd5, 16'd7},
        '{16'd5, 16'd0, 16'd0, 16'd0},
        '{16'd1, 16'd4, 16'd1, 16'd2}};
    localparam logic [31:0] V_STR  [NV][4] = '{
        '{32'd4,          32'd8,  32'h100, 32'h1000},
        '{32'd4,          32'h40, 32'd9,   32'd9},
        '{32'hFFFF_FFFC,  32'd0,  32'd0,   32'd0},
        '{32'd4,          32'h10, 32'h20,  32'h30}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [1:0]  cfg_lvl = '0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        stream_en = 1'b1;
    logic        addr_valid;
    logic        addr_ready = 1'b0;
    logic [31:0] addr;
    logic        done;

    int checks = 0;
    int bad = 0;

    always #4 clk = ~clk;

    affine_stream_agu u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_lvl(cfg_lvl), .cfg_wdata(cfg_wdata), .start(start),
        .stream_en(stream_en), .addr_valid(addr_valid), .addr_ready(addr_ready),
        .addr(addr), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [1:0] lvl, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = kind; cfg_lvl = lvl; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: kinds 0 base, 1 bound, 2 stride, 3 count-1
    task automatic load_vec(input int v);
        wr(2'd0, 2'd0, V_BASE[v]);
        wr(2'd3, 2'd0, {30'd0, V_DIMS[v]});
        for (int d = 0; d < 4; d++) begin
            wr(2'd1, 2'(d), {16'd0, V_BND[v][d]});
            wr(2'd2, 2'(d), V_STR[v][d]);
        end
    endtask

    function automatic int total_of(input int v);
        int t = 1;
        for (int d = 0; d <= int'(V_DIMS[v]); d++) t *= int'(V_BND[v][d]);
        return t;
    endfunction

    function automatic logic [31:0] exp_addr(input int v, input int k);
        logic [31:0] a = V_BASE[v];
        int rem = k;
        for (int d = 0; d <= int'(V_DIMS[v]); d++) begin
            a += 32'(rem % int'(V_BND[v][d])) * V_STR[v][d];
            rem = rem / int'(V_BND[v][d]);
        end
        return a;
    endfunction

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Walk one vector; stall selects a ready pattern with gaps
    task automatic run_vec(input int v, input bit stall);
        int total = total_of(v);
        int k = 0;
        int cyc = 0;
        bit seen_done = 1'b0;
        bit prev_hold = 1'b0;
        logic [31:0] prev_addr = '0;
        pulse_start();
        while (!seen_done && cyc < 2000) begin
            addr_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            #1;
            if (prev_hold) check(addr == prev_addr, "R4 hold", addr, prev_addr);
            if (k == total) begin
                check(done == 1'b1, "R6 done after last", {31'd0, done}, 32'd1);
                check(addr_valid == 1'b0, "R6 no extra address", {31'd0, addr_valid}, 32'd0);
                seen_done = 1'b1;
            end else begin
                check(done == 1'b0, "R6 early done", {31'd0, done}, 32'd0);
                if (!stall) check(addr_valid == 1'b1, "R3 back-to-back", {31'd0, addr_valid}, 32'd1);
                if (addr_valid && addr_ready) begin
                    check(addr == exp_addr(v, k), "R2/R9 address", addr, exp_addr(v, k));
                    k++;
                end
            end
            prev_hold = addr_valid && !addr_ready;
            prev_addr = addr;
            @(negedge clk);
            cyc++;
        end
        addr_ready = 1'b0;
        check(seen_done, "R6 walk ended", 32'(k), 32'(total));
        #1;
        check(done == 1'b0, "R6 single pulse", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(addr_valid == 1'b0, "R1 reset valid", {31'd0, addr_valid}, 32'd0);
        check(done == 1'b0, "R1 reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            run_vec(v, (v % 2) == 1);
        end

        // R5: disabled stream issues nothing, then resumes at the first address
        load_vec(0);
        stream_en = 1'b0;
        addr_ready = 1'b1;
        pulse_start();
        for (int i = 0; i < 4; i++) begin
            #1;
            check(addr_valid == 1'b0, "R5 quiet while off", {31'd0, addr_valid}, 32'd0);
            @(negedge clk);
        end
        stream_en = 1'b1;
        #1;
        check(addr_valid == 1'b1 && addr == V_BASE[0], "R5 resume", addr, V_BASE[0]);
        addr_ready = 1'b0;

        // R7: a write while busy is dropped
        wr(2'd0, 2'd0, 32'hDEAD_0000);
        addr_ready = 1'b1;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        addr_ready = 1'b0;
        @(negedge clk);
        pulse_start();
        #1;
        check(addr == V_BASE[0], "R7 busy write ignored", addr, V_BASE[0]);
        addr_ready = 1'b1;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        addr_ready = 1'b0;
        @(negedge clk);

        // R8: zero bound on an active level
        load_vec(3);
        wr(2'd1, 2'd2, 32'd0);
        addr_ready = 1'b1;
        pulse_start();
        #1;
        check(done == 1'b1, "R8 immediate done", {31'd0, done}, 32'd1);
        check(addr_valid == 1'b0, "R8 no address", {31'd0, addr_valid}, 32'd0);
        @(negedge clk);
        #1;
        check(done == 1'b0 && addr_valid == 1'b0, "R8 back to idle", {30'd0, done, addr_valid}, 32'd0);

        // R9: zero bound on an inactive level does not block the walk
        wr(2'd3, 2'd0, 32'd1);
        wr(2'd1, 2'd2, 32'd0);
        wr(2'd1, 2'd0, 32'd1);
        pulse_start();
        #1;
        check(addr_valid == 1'b1 && addr == V_BASE[3], "R9 inactive level ignored", addr, V_BASE[3]);
        for (int i = 0; i < 50 && !done; i++) @(negedge clk);
        addr_ready = 1'b0;

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule